// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the instruction sequencer of a small 4-bit CPU core and decides when a pending interrupt is taken. It watches two requests. The first is a non-maskable request, `nmiN`, which is taken on its falling edge. The second is an active-low maskable level, `irqN`, which is gated by the core's interrupt-enable flag. One clock of this block is one bus cycle. A request counts as sampled at the clock edge that closes the bus cycle, which plays the role of the T3 sampling point.

A request is taken only at an instruction boundary, which the core marks with `instrEnd`. After that the block runs a fixed four-cycle entry sequence:

1. A dummy fetch, with the acknowledge strobes going low.
2. A push of the flag nibble to the flag stack, together with a clear of the enable flag.
3. A vector read from the data bus under a read strobe, with the bus status set to 01b.
4. A fetch from the vector address, together with a push of the saved return address to the program stack.

`busy` holds the normal sequencer off for those four cycles. A non-maskable entry skips the vector read and always lands at 0x0100.

After an instruction that writes the flag or extension state, the boundary that closes that instruction is not an acceptance point. A pending request waits for one more instruction.

Top module: `intEntrySeq`

## Requirements
- R1: After reset `busy`, `dummyFetch`, `stk1Wr`, `stk2Wr`, `iFlagClr` and `vecFetch` are 0, `iackN`, `nackN` and `rdivN` are 1 and `dbs` is 00.
- R2: A maskable entry starts only at a clock edge where the block is idle, `instrEnd`=1, `irqN`=0 and `iFlag`=1. With `iFlag`=0 or `instrEnd`=0 no entry starts, and a level still low when `iFlag` returns to 1 is taken at the next boundary.
- R3: A falling edge of `nmiN` is held pending until taken, whatever `iFlag` is. One edge yields exactly one entry, even if `nmiN` stays low.
- R4: When a non-maskable request and a maskable request are both pending at a boundary, the non-maskable one is taken first.
- R5: Sequence cycle 1 has `busy`=1, `dummyFetch`=1 and `iackN`=0. `nackN`=0 holds only for a non-maskable entry.
- R6: Sequence cycle 2 has `stk2Wr`=1 with `stk2Data` equal to `flagIn`, and `iFlagClr`=1. Both acknowledges stay low.
- R7: Sequence cycle 3 of a maskable entry has `dbs`=01, `rdivN`=0 and captures `dataBus`. For a non-maskable entry `dbs`=00 and `rdivN`=1. The acknowledges are low in this cycle and high from cycle 4 on.
- R8: Sequence cycle 4 has `vecFetch`=1 with `vecAddr` = 0x0100 OR the captured nibble (0x0100 for non-maskable), and `stk1Wr`=1 with `stk1Data` equal to `pcNext` as sampled at the accepting edge.
- R9: `busy` is high for exactly four cycles per entry, and no new entry starts while it is high.
- R10: If `flagWrFetch`=1 in a cycle, no entry starts at that cycle's edge nor at the next `instrEnd` edge. The boundary after that is an acceptance point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock; the rising edge is the sampling point |
| rstN | input | 1 | Active-low synchronous reset |
| nmiN | input | 1 | Non-maskable request, falling-edge sensitive |
| irqN | input | 1 | Maskable request, active low level |
| iFlag | input | 1 | Current interrupt-enable flag of the core |
| instrEnd | input | 1 | This cycle is the last execution cycle of an instruction |
| flagWrFetch | input | 1 | The instruction fetched this cycle writes the flag or extension state |
| pcNext | input | 16 | Return address the core would continue at |
| dataBus | input | 4 | Data bus nibble carrying the vector |
| flagIn | input | 4 | Current flag register value |
| busy | output | 1 | Entry sequence in progress; stalls normal sequencing |
| dummyFetch | output | 1 | Current cycle is the dummy fetch |
| nackN | output | 1 | Non-maskable acknowledge, active low |
| iackN | output | 1 | Interrupt acknowledge, active low |
| rdivN | output | 1 | Vector read strobe, active low |
| dbs | output | 2 | Data bus status code |
| stk2Wr | output | 1 | Flag-stack push request |
| stk2Data | output | 4 | Flag value to push |
| iFlagClr | output | 1 | Request to clear the enable flag |
| stk1Wr | output | 1 | Program-stack push request |
| stk1Data | output | 16 | Return address to push |
| vecFetch | output | 1 | Fetch from the vector address this cycle |
| vecAddr | output | 16 | Vector address |

## Verification
Entries are driven with the maskable line alone under several vector nibbles and return addresses. These runs show that the captured bus value, not a constant, forms the low address nibble, and that the return address is latched at the accepting edge. A non-maskable entry with the enable flag clear separates the two acknowledge paths and the dummy vector cycle. A case with both requests pending shows the order they are taken in. Held-low levels, a missing boundary, a clear enable flag and a flag-writing fetch each probe a reason for refusal, and `busy` is checked at the ports after each one.

// File: rtl/intseqPkg.sv
package intseqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSHF,
    ST_VEC,
    ST_PUSHPC
  } seqState_t;

  typedef struct packed {
    logic capPc;
    logic capVec;
    logic nmiSel;
  } dpStrobe_t;

endpackage

// File: rtl/intseqCtrl.sv
module intseqCtrl
  import intseqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      nmiN,
  input  logic      irqN,
  input  logic      iFlag,
  input  logic      instrEnd,
  input  logic      flagWrFetch,
  output logic      busy,
  output logic      dummyFetch,
  output logic      nackN,
  output logic      iackN,
  output logic      rdivN,
  output logic [1:0] dbs,
  output logic      stk2Wr,
  output logic      iFlagClr,
  output logic      stk1Wr,
  output logic      vecFetch,
  output dpStrobe_t stb
);

  localparam logic [1:0] DBS_IDLE = 2'b00;
  localparam logic [1:0] DBS_VEC  = 2'b01;

  seqState_t st, stNext;
  logic nmiPrev, nmiPend, shadow, curNmi;
  logic nmiFall, irqReq, shadowOn, acceptNow, ackPhase;

  assign nmiFall   = nmiPrev & ~nmiN;
  assign irqReq    = ~irqN & iFlag;
  assign shadowOn  = shadow | flagWrFetch;
  assign acceptNow = (st == ST_IDLE) & instrEnd & ~shadowOn & (nmiPend | irqReq);

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE:   if (acceptNow) stNext = ST_ACK;
      ST_ACK:    stNext = ST_PUSHF;
      ST_PUSHF:  stNext = ST_VEC;
      ST_VEC:    stNext = ST_PUSHPC;
      ST_PUSHPC: stNext = ST_IDLE;
      default:   stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
      shadow  <= 1'b0;
      curNmi  <= 1'b0;
    end else begin
      st      <= stNext;
      nmiPrev <= nmiN;
      if (acceptNow && nmiPend) nmiPend <= nmiFall;
      else if (nmiFall)         nmiPend <= 1'b1;
      if (flagWrFetch)   shadow <= 1'b1;
      else if (instrEnd) shadow <= 1'b0;
      if (acceptNow) curNmi <= nmiPend;
    end
  end

  assign ackPhase   = (st == ST_ACK) | (st == ST_PUSHF) | (st == ST_VEC);
  assign busy       = (st != ST_IDLE);
  assign dummyFetch = (st == ST_ACK);
  assign iackN      = ~ackPhase;
  assign nackN      = ~(ackPhase & curNmi);
  assign rdivN      = ~((st == ST_VEC) & ~curNmi);
  assign dbs        = ((st == ST_VEC) & ~curNmi) ? DBS_VEC : DBS_IDLE;
  assign stk2Wr     = (st == ST_PUSHF);
  assign iFlagClr   = (st == ST_PUSHF);
  assign stk1Wr     = (st == ST_PUSHPC);
  assign vecFetch   = (st == ST_PUSHPC);

  assign stb.capPc  = acceptNow;
  assign stb.capVec = (st == ST_VEC);
  assign stb.nmiSel = curNmi;

  a_r2_entry_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instrEnd));
  a_r5_ack_starts_with_dummy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iackN) |-> dummyFetch);
  a_r5_nack_implies_iack: assert property (@(posedge clk) disable iff (!rstN)
    !nackN |-> !iackN);
  a_r9_idle_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |=> !busy);
  a_r10_no_entry_in_shadow: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flagWrFetch) |=> !busy);

endmodule

// File: rtl/intseqDp.sv
module intseqDp
  import intseqPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int VEC_W  = 4,
  parameter int FLAG_W = 4,
  parameter logic [PC_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              vecFetch,
  input  logic [PC_W-1:0]   pcNext,
  input  logic [VEC_W-1:0]  dataBus,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [FLAG_W-1:0] stk2Data,
  output logic [PC_W-1:0]   stk1Data,
  output logic [PC_W-1:0]   vecAddr
);

  localparam int HI_W = PC_W - VEC_W;

  logic [PC_W-1:0]  pcSave;
  logic [VEC_W-1:0] vecNib;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSave <= '0;
      vecNib <= '0;
    end else begin
      if (stb.capPc)  pcSave <= pcNext;
      if (stb.capVec) vecNib <= stb.nmiSel ? '0 : dataBus;
    end
  end

  assign stk2Data = flagIn;
  assign stk1Data = pcSave;
  assign vecAddr  = VEC_BASE | PC_W'(vecNib);

  a_r8_vector_page: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |-> (vecAddr[PC_W-1:VEC_W] == VEC_BASE[PC_W-1:VEC_W]));
  a_r8_fetch_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |-> $past(stb.capVec));
  a_r8_pc_held: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |-> $stable(pcSave));

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intseqPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int VEC_W  = 4,
  parameter int FLAG_W = 4,
  parameter logic [PC_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiN,
  input  logic              irqN,
  input  logic              iFlag,
  input  logic              instrEnd,
  input  logic              flagWrFetch,
  input  logic [PC_W-1:0]   pcNext,
  input  logic [VEC_W-1:0]  dataBus,
  input  logic [FLAG_W-1:0] flagIn,
  output logic              busy,
  output logic              dummyFetch,
  output logic              nackN,
  output logic              iackN,
  output logic              rdivN,
  output logic [1:0]        dbs,
  output logic              stk2Wr,
  output logic [FLAG_W-1:0] stk2Data,
  output logic              iFlagClr,
  output logic              stk1Wr,
  output logic [PC_W-1:0]   stk1Data,
  output logic              vecFetch,
  output logic [PC_W-1:0]   vecAddr
);

  dpStrobe_t stb;

  intseqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .irqN(irqN), .iFlag(iFlag),
    .instrEnd(instrEnd), .flagWrFetch(flagWrFetch),
    .busy(busy), .dummyFetch(dummyFetch), .nackN(nackN), .iackN(iackN),
    .rdivN(rdivN), .dbs(dbs), .stk2Wr(stk2Wr), .iFlagClr(iFlagClr),
    .stk1Wr(stk1Wr), .vecFetch(vecFetch), .stb(stb)
  );

  intseqDp #(.PC_W(PC_W), .VEC_W(VEC_W), .FLAG_W(FLAG_W), .VEC_BASE(VEC_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .vecFetch(vecFetch), .pcNext(pcNext),
    .dataBus(dataBus), .flagIn(flagIn), .stk2Data(stk2Data),
    .stk1Data(stk1Data), .vecAddr(vecAddr)
  );

endmodule

// File: tb/intEntrySeq_tb.sv
module intEntrySeq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiN = 1'b1, irqN = 1'b1, iFlag = 1'b0, instrEnd = 1'b0, flagWrFetch = 1'b0;
  logic [15:0] pcNext = '0;
  logic [3:0]  dataBus = '0, flagIn = '0;
  logic busy, dummyFetch, nackN, iackN, rdivN, stk2Wr, iFlagClr, stk1Wr, vecFetch;
  logic [1:0]  dbs;
  logic [3:0]  stk2Data;
  logic [15:0] stk1Data, vecAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intEntrySeq dut_i (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .irqN(irqN), .iFlag(iFlag),
    .instrEnd(instrEnd), .flagWrFetch(flagWrFetch), .pcNext(pcNext),
    .dataBus(dataBus), .flagIn(flagIn), .busy(busy), .dummyFetch(dummyFetch),
    .nackN(nackN), .iackN(iackN), .rdivN(rdivN), .dbs(dbs), .stk2Wr(stk2Wr),
    .stk2Data(stk2Data), .iFlagClr(iFlagClr), .stk1Wr(stk1Wr),
    .stk1Data(stk1Data), .vecFetch(vecFetch), .vecAddr(vecAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one instruction boundary; returns at the negedge after the sampling edge
  task automatic endInstr();
    instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
  endtask

  task automatic checkEntry(input bit isNmi, input logic [3:0] nib, input logic [15:0] pc,
                            input logic [3:0] flg);
    dataBus = nib;
    flagIn  = flg;
    chk("R5 busy", busy, 1);
    chk("R5 dummy", dummyFetch, 1);
    chk("R5 iack", iackN, 0);
    chk("R5 nack", nackN, isNmi ? 0 : 1);
    @(negedge clk);
    chk("R6 push flags", {stk2Wr, iFlagClr}, 2'b11);
    chk("R6 flag data", stk2Data, flg);
    chk("R6 acks", {nackN, iackN}, {~isNmi, 1'b0});
    @(negedge clk);
    chk("R7 dbs", dbs, isNmi ? 2'b00 : 2'b01);
    chk("R7 rdiv", rdivN, isNmi ? 1 : 0);
    chk("R7 iack low", iackN, 0);
    @(negedge clk);
    dataBus = ~nib;
    chk("R7 acks released", {nackN, iackN}, 2'b11);
    chk("R8 fetch", {vecFetch, stk1Wr}, 2'b11);
    chk("R8 addr", vecAddr, isNmi ? 16'h0100 : (16'h0100 | nib));
    chk("R8 pc push", stk1Data, pc);
    chk("R9 busy cycle4", busy, 1);
    @(negedge clk);
    chk("R9 busy ends", busy, 0);
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {dummyFetch, stk1Wr, stk2Wr, iFlagClr, vecFetch}, 0);
    chk("R1 lows", {iackN, nackN, rdivN}, 3'b111);
    chk("R1 dbs", dbs, 0);
  endtask

  task automatic testIrqBasic();
    iFlag = 1; irqN = 0; pcNext = 16'h1234;
    endInstr();
    pcNext = 16'hFFFF;
    checkEntry(0, 4'h5, 16'h1234, 4'hA);
    pcNext = 16'h0ABC;
    endInstr();
    pcNext = 16'h0000;
    checkEntry(0, 4'hF, 16'h0ABC, 4'h3);
    irqN = 1;
  endtask

  task automatic testIrqMasked();
    iFlag = 0; irqN = 0;
    endInstr();
    chk("R2 masked no entry", busy, 0);
    iFlag = 1;
    @(negedge clk);
    chk("R2 no boundary no entry", busy, 0);
    pcNext = 16'h0777;
    endInstr();
    checkEntry(0, 4'h1, 16'h0777, 4'h0);
    irqN = 1;
  endtask

  task automatic testNmi();
    iFlag = 0;
    nmiN = 0;
    @(negedge clk);
    @(negedge clk);
    pcNext = 16'h2222;
    endInstr();
    checkEntry(1, 4'h9, 16'h2222, 4'h6);
    endInstr();
    chk("R3 one entry per edge", busy, 0);
    nmiN = 1;
    @(negedge clk);
  endtask

  task automatic testPriority();
    iFlag = 1; irqN = 0; nmiN = 0;
    @(negedge clk);
    pcNext = 16'h3000;
    endInstr();
    chk("R4 nmi first", nackN, 0);
    checkEntry(1, 4'h4, 16'h3000, 4'h1);
    nmiN = 1;
    pcNext = 16'h3001;
    endInstr();
    chk("R4 irq second", nackN, 1);
    checkEntry(0, 4'h4, 16'h3001, 4'h1);
    irqN = 1;
  endtask

  task automatic testShadow();
    iFlag = 1; irqN = 0;
    flagWrFetch = 1;
    endInstr();
    flagWrFetch = 0;
    chk("R10 fetch boundary blocked", busy, 0);
    endInstr();
    chk("R10 flag instr boundary blocked", busy, 0);
    pcNext = 16'h4444;
    endInstr();
    checkEntry(0, 4'hC, 16'h4444, 4'h8);
    irqN = 1;
  endtask

  task automatic testNoReentry();
    iFlag = 1; irqN = 0;
    endInstr();
    instrEnd = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R9 still in sequence", vecFetch, 1);
    @(negedge clk);
    instrEnd = 0;
    chk("R9 no reentry while busy", busy, 0);
    irqN = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testIrqBasic();
    testIrqMasked();
    testNmi();
    testPriority();
    testShadow();
    testNoReentry();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule